// File: doc/BRIEF.md
# Tag-Broadcast Reservation Station

This block holds decoded instructions between issue and execution for a single execution unit. Source operands are read from a small register file when the instruction is issued. A register whose scoreboard bit is set supplies its value at once. A register that is still waiting for a result leaves its register number in the entry as a tag, with the operand marked not ready. When a result appears on the broadcast bus, it writes the register file. Every waiting entry compares its tags against the broadcast destination and takes the value on a match.

Each cycle the station can accept one instruction and dispatch one. Of the entries whose two operands are both ready, the oldest is sent to the execution unit, which always accepts it. Entries are kept packed in age order, so position zero is always the oldest. A mode input lets a fully ready instruction go straight to the execution unit when the station holds nothing. With the mode off, every instruction waits at least one cycle in the station.

Top module: `tagcap_rs`

## Requirements
- R1: After reset the station is empty, `disp_valid` and `full` are 0, and register n holds 16'h00A0 + n with its ready bit set.
- R2: At issue, a source whose register is ready is stored as its value. A source whose register is not ready is stored as its register number, and the entry waits.
- R3: An accepted issue clears the ready bit of its destination register. A later consumer of that register waits for a broadcast of that register.
- R4: A broadcast writes the value into the named register and sets its ready bit. Every stored operand waiting on that register number takes the value, and the entry can dispatch from the next cycle.
- R5: A broadcast in the same cycle as an issue that reads the broadcast register is forwarded into the new instruction as a ready operand.
- R6: An entry dispatches only when both operands are ready. At most one instruction dispatches per cycle, presenting opcode, operand A, operand B and destination.
- R7: When several entries are ready, the one issued earliest dispatches first.
- R8: With `skip_en` = 0, an instruction dispatches no earlier than the cycle after it was issued, even when its operands are ready at issue.
- R9: With `skip_en` = 1, the station empty and both operands ready at issue (including by forwarding), the instruction dispatches in its issue cycle and is not stored.
- R10: `full` is 1 when NUM_ENT entries are held. An issue while `full` is 1 is ignored: nothing is stored, nothing is dispatched for it, and its destination's ready bit is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| skip_en | input | 1 | Lets a ready instruction pass an empty station in its issue cycle |
| iss_valid | input | 1 | Issue request this cycle |
| iss_op | input | 4 | Opcode of the issued instruction |
| iss_src_a | input | 3 | Register number of source A |
| iss_src_b | input | 3 | Register number of source B |
| iss_dst | input | 3 | Destination register number |
| full | output | 1 | Station holds NUM_ENT entries; issue is refused |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | 3 | Register number the result belongs to |
| res_data | input | 16 | Result value |
| disp_valid | output | 1 | An instruction is sent to the execution unit this cycle |
| disp_op | output | 4 | Dispatched opcode |
| disp_a | output | 16 | Dispatched operand A value |
| disp_b | output | 16 | Dispatched operand B value |
| disp_dst | output | 3 | Dispatched destination register |

## Verification
Two functions meet in one cycle when a broadcast of a register arrives together with the issue of an instruction that reads it. The stimulus sets `res_valid` in the same cycle as that issue, with the station both holding entries and empty under `skip_en`. It is judged by the dispatched operand value: the stored case shows it one cycle later, and the bypass case shows it in that same cycle. Dispatch and append also share cycles: an older entry leaves while a new one enters, and a later dispatch that reports the new instruction's fields proves that the compaction kept age order.

// File: rtl/tagcap_pkg.sv
package tagcap_pkg;
    localparam int TC_DATA_W = 16;
    localparam int TC_OP_W   = 4;
    localparam int TC_REG_N  = 8;
    localparam int TC_RA_W   = $clog2(TC_REG_N);
    localparam logic [TC_DATA_W-1:0] TC_RST_BASE = 16'h00A0;

    typedef logic [TC_DATA_W-1:0] word_t;
    typedef logic [TC_RA_W-1:0]   ra_t;
    typedef logic [TC_OP_W-1:0]   op_t;

    // operand slot: value when rdy, otherwise low bits carry the awaited register
    typedef struct packed {
        logic  rdy;
        word_t v;
    } opnd_t;

    typedef struct packed {
        op_t   op;
        opnd_t a;
        opnd_t b;
        ra_t   dst;
    } ent_t;

    typedef struct packed {
        logic  vld;
        ra_t   tag;
        word_t data;
    } bcast_t;

    function automatic opnd_t fetch_opnd(ra_t ra, word_t rf_v, logic rf_ok, bcast_t bc);
        opnd_t o;
        if (rf_ok) begin
            o.rdy = 1'b1;
            o.v   = rf_v;
        end else if (bc.vld && bc.tag == ra) begin
            o.rdy = 1'b1;
            o.v   = bc.data;
        end else begin
            o.rdy = 1'b0;
            o.v   = word_t'(ra);
        end
        return o;
    endfunction

    function automatic opnd_t snoop(opnd_t o, bcast_t bc);
        opnd_t r;
        r = o;
        if (!o.rdy && bc.vld && o.v[TC_RA_W-1:0] == bc.tag) begin
            r.rdy = 1'b1;
            r.v   = bc.data;
        end
        return r;
    endfunction
endpackage

// File: rtl/tagcap_regfile.sv
module tagcap_regfile
    import tagcap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ra_t    rd_a,
    input  ra_t    rd_b,
    output word_t  val_a,
    output logic   ok_a,
    output word_t  val_b,
    output logic   ok_b,
    input  bcast_t bc,
    input  logic   clr,
    input  ra_t    clr_ra
);
    typedef struct packed {
        logic [TC_REG_N-1:0][TC_DATA_W-1:0] val;
        logic [TC_REG_N-1:0]                ok;
    } rf_st_t;

    rf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bc.vld) begin
            st_d.val[bc.tag] = bc.data;
            st_d.ok[bc.tag]  = 1'b1;
        end
        // a new producer supersedes a result landing in the same cycle
        if (clr) begin
            st_d.ok[clr_ra] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TC_REG_N; i++) begin
                st_q.val[i] <= TC_RST_BASE + word_t'(i);
            end
            st_q.ok <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_a = st_q.val[rd_a];
    assign ok_a  = st_q.ok[rd_a];
    assign val_b = st_q.val[rd_b];
    assign ok_b  = st_q.ok[rd_b];

    AST_BCAST_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (bc.vld && !(clr && clr_ra == bc.tag)) |=>
        (st_q.ok[$past(bc.tag)] && st_q.val[$past(bc.tag)] == $past(bc.data))); // R4

    AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !st_q.ok[$past(clr_ra)]); // R3
endmodule

// File: rtl/tagcap_oldest.sv
module tagcap_oldest #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // position 0 holds the oldest entry, so the lowest requester wins
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tagcap_station.sv
module tagcap_station
    import tagcap_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  ent_t                      push_ent,
    input  bcast_t                    bc,
    input  logic                      pop,
    input  logic [IDX_W-1:0]          pop_idx,
    output ent_t [NUM_ENT-1:0]        ents,
    output logic [NUM_ENT-1:0]        rdy,
    output logic [CNT_W-1:0]          cnt
);
    typedef struct packed {
        ent_t [NUM_ENT-1:0] e;
        logic [CNT_W-1:0]   cnt;
    } st_t;

    st_t                st_d, st_q;
    ent_t [NUM_ENT-1:0] woke;
    logic [CNT_W-1:0]   cnt_mid;

    always_comb begin
        // associative capture across every slot
        for (int i = 0; i < NUM_ENT; i++) begin
            woke[i]   = st_q.e[i];
            woke[i].a = snoop(st_q.e[i].a, bc);
            woke[i].b = snoop(st_q.e[i].b, bc);
        end
        st_d.e  = woke;
        cnt_mid = st_q.cnt;
        // close the gap left by the dispatched slot, keeping age order
        if (pop) begin
            for (int i = 0; i < NUM_ENT - 1; i++) begin
                if (IDX_W'(i) >= pop_idx) begin
                    st_d.e[i] = woke[i + 1];
                end
            end
            cnt_mid = st_q.cnt - CNT_W'(1);
        end
        // append behind the youngest survivor
        if (push) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (CNT_W'(i) == cnt_mid) begin
                    st_d.e[i] = push_ent;
                end
            end
        end
        st_d.cnt = cnt_mid + (push ? CNT_W'(1) : CNT_W'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_ENT; g++) begin : g_rdy
            assign rdy[g] = (CNT_W'(g) < st_q.cnt) && st_q.e[g].a.rdy && st_q.e[g].b.rdy;
        end
    endgenerate

    assign ents = st_q.e;
    assign cnt  = st_q.cnt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(NUM_ENT)); // R10

    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt != CNT_W'(NUM_ENT))); // R10

    AST_POP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> rdy[pop_idx]); // R6
endmodule

// File: rtl/tagcap_rs.sv
module tagcap_rs
    import tagcap_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 skip_en,
    input  logic                 iss_valid,
    input  logic [TC_OP_W-1:0]   iss_op,
    input  logic [TC_RA_W-1:0]   iss_src_a,
    input  logic [TC_RA_W-1:0]   iss_src_b,
    input  logic [TC_RA_W-1:0]   iss_dst,
    output logic                 full,
    input  logic                 res_valid,
    input  logic [TC_RA_W-1:0]   res_tag,
    input  logic [TC_DATA_W-1:0] res_data,
    output logic                 disp_valid,
    output logic [TC_OP_W-1:0]   disp_op,
    output logic [TC_DATA_W-1:0] disp_a,
    output logic [TC_DATA_W-1:0] disp_b,
    output logic [TC_RA_W-1:0]   disp_dst
);
    bcast_t             bc;
    word_t              rf_va, rf_vb;
    logic               rf_oka, rf_okb;
    opnd_t              opa, opb;
    ent_t               new_ent, sel_ent;
    ent_t [NUM_ENT-1:0] ents;
    logic [NUM_ENT-1:0] rdy, gnt;
    logic [IDX_W-1:0]   sel_idx;
    logic               sel_any;
    logic [CNT_W-1:0]   cnt;
    logic               acc, byp, push;

    assign bc = '{vld: res_valid, tag: res_tag, data: res_data};

    tagcap_regfile u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_a   (iss_src_a),
        .rd_b   (iss_src_b),
        .val_a  (rf_va),
        .ok_a   (rf_oka),
        .val_b  (rf_vb),
        .ok_b   (rf_okb),
        .bc     (bc),
        .clr    (acc),
        .clr_ra (iss_dst)
    );

    assign opa     = fetch_opnd(iss_src_a, rf_va, rf_oka, bc);
    assign opb     = fetch_opnd(iss_src_b, rf_vb, rf_okb, bc);
    assign new_ent = '{op: iss_op, a: opa, b: opb, dst: iss_dst};

    assign full = (cnt == CNT_W'(NUM_ENT));
    assign acc  = iss_valid && !full;
    assign byp  = acc && skip_en && (cnt == '0) && opa.rdy && opb.rdy;
    assign push = acc && !byp;

    tagcap_station #(.NUM_ENT(NUM_ENT)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent (new_ent),
        .bc       (bc),
        .pop      (sel_any),
        .pop_idx  (sel_idx),
        .ents     (ents),
        .rdy      (rdy),
        .cnt      (cnt)
    );

    tagcap_oldest #(.N(NUM_ENT)) u_pick (
        .req (rdy),
        .gnt (gnt),
        .idx (sel_idx),
        .any (sel_any)
    );

    assign sel_ent = ents[sel_idx];

    always_comb begin
        disp_valid = 1'b0;
        disp_op    = '0;
        disp_a     = '0;
        disp_b     = '0;
        disp_dst   = '0;
        if (sel_any) begin
            disp_valid = 1'b1;
            disp_op    = sel_ent.op;
            disp_a     = sel_ent.a.v;
            disp_b     = sel_ent.b.v;
            disp_dst   = sel_ent.dst;
        end else if (byp) begin
            disp_valid = 1'b1;
            disp_op    = new_ent.op;
            disp_a     = new_ent.a.v;
            disp_b     = new_ent.b.v;
            disp_dst   = new_ent.dst;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (sel_any == (gnt != '0))); // R7

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byp && sel_any)); // R9

    AST_MIN_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!skip_en && disp_valid) |-> sel_any); // R8
endmodule

// File: tb/tb_tagcap_rs.sv
`timescale 1ns/1ps
module tb_tagcap_rs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        skip_en, iss_valid, res_valid;
    logic [3:0]  iss_op;
    logic [2:0]  iss_src_a, iss_src_b, iss_dst, res_tag;
    logic [15:0] res_data;
    logic        full, disp_valid;
    logic [3:0]  disp_op;
    logic [15:0] disp_a, disp_b;
    logic [2:0]  disp_dst;

    int nchk  = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    tagcap_rs #(.NUM_ENT(4)) dut (
        .clk(clk), .rst_n(rst_n), .skip_en(skip_en),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_src_a(iss_src_a),
        .iss_src_b(iss_src_b), .iss_dst(iss_dst), .full(full),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_a(disp_a),
        .disp_b(disp_b), .disp_dst(disp_dst)
    );

    typedef struct packed {
        logic        sk;
        logic        iv;
        logic [3:0]  op;
        logic [2:0]  sa;
        logic [2:0]  sb;
        logic [2:0]  d;
        logic        rv;
        logic [2:0]  rt;
        logic [15:0] rd;
        logic        ev;
        logic [3:0]  eop;
        logic [15:0] ea;
        logic [15:0] eb;
        logic [2:0]  ed;
    } vec_t;

    // sk iv op sa sb d | rv rt rd | ev eop ea eb ed
    localparam vec_t VEC [24] = '{
        '{0,1,1,1,2,3, 0,0,'h0000, 0,0,'h0000,'h0000,0}, // R8 ready entry waits
        '{0,1,2,3,4,5, 0,0,'h0000, 1,1,'h00A1,'h00A2,3}, // R2 R3 tag kept for r3
        '{0,1,3,5,3,6, 1,3,'h1234, 0,0,'h0000,'h0000,0}, // R5 forward r3 at issue
        '{0,0,0,0,0,0, 0,0,'h0000, 1,2,'h1234,'h00A4,5}, // R4 woken entry
        '{0,0,0,0,0,0, 1,5,'h0055, 0,0,'h0000,'h0000,0},
        '{0,0,0,0,0,0, 0,0,'h0000, 1,3,'h0055,'h1234,6}, // R4 R5
        '{0,1,4,6,6,7, 0,0,'h0000, 0,0,'h0000,'h0000,0},
        '{0,1,5,0,1,2, 0,0,'h0000, 0,0,'h0000,'h0000,0},
        '{0,1,6,2,2,4, 0,0,'h0000, 1,5,'h00A0,'h00A1,2}, // R6 younger ready, older blocked
        '{0,1,7,1,1,0, 1,6,'h0666, 0,0,'h0000,'h0000,0},
        '{0,1,8,3,0,1, 1,2,'h0222, 1,4,'h0666,'h0666,7}, // R7 oldest of two ready
        '{0,1,9,1,1,3, 0,0,'h0000, 1,6,'h0222,'h0222,4}, // R7 order kept after shift
        '{0,0,0,0,0,0, 0,0,'h0000, 1,7,'h00A1,'h00A1,0},
        '{0,0,0,0,0,0, 1,0,'h0F0F, 0,0,'h0000,'h0000,0},
        '{0,0,0,0,0,0, 1,1,'h0101, 1,8,'h1234,'h0F0F,1},
        '{0,0,0,0,0,0, 0,0,'h0000, 1,9,'h0101,'h0101,3},
        '{1,1,10,2,6,7, 0,0,'h0000, 1,10,'h0222,'h0666,7}, // R9 bypass
        '{1,1,11,7,5,3, 1,7,'h0777, 1,11,'h0777,'h0055,3}, // R9 R5 bypass with forward
        '{1,1,12,3,0,4, 0,0,'h0000, 0,0,'h0000,'h0000,0},  // R9 not ready -> stored
        '{1,1,13,0,1,2, 0,0,'h0000, 0,0,'h0000,'h0000,0},  // R9 station busy -> stored
        '{0,0,0,0,0,0, 1,3,'h0333, 1,13,'h0F0F,'h0101,2},
        '{0,0,0,0,0,0, 0,0,'h0000, 1,12,'h0333,'h0F0F,4},
        '{0,1,14,5,6,0, 0,0,'h0000, 0,0,'h0000,'h0000,0}, // R8 no bypass when disabled
        '{0,0,0,0,0,0, 0,0,'h0000, 1,14,'h0055,'h0666,0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic sk, input logic iv, input logic [3:0] op,
                       input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] d,
                       input logic rv, input logic [2:0] rt, input logic [15:0] rd);
        @(negedge clk);
        skip_en = sk; iss_valid = iv; iss_op = op; iss_src_a = sa;
        iss_src_b = sb; iss_dst = d; res_valid = rv; res_tag = rt; res_data = rd;
        #1;
    endtask

    task automatic see(input string req, input logic ev, input logic [3:0] eop,
                       input logic [15:0] ea, input logic [15:0] eb, input logic [2:0] ed);
        chk({req, " disp_valid"}, 32'(disp_valid), 32'(ev));
        if (ev) begin
            chk({req, " disp_op"}, 32'(disp_op), 32'(eop));
            chk({req, " disp_a"}, 32'(disp_a), 32'(ea));
            chk({req, " disp_b"}, 32'(disp_b), 32'(eb));
            chk({req, " disp_dst"}, 32'(disp_dst), 32'(ed));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        skip_en = 0; iss_valid = 0; iss_op = 0; iss_src_a = 0; iss_src_b = 0;
        iss_dst = 0; res_valid = 0; res_tag = 0; res_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1000000;
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk("R1 reset disp_valid", 32'(disp_valid), 0);
        chk("R1 reset full", 32'(full), 0);

        for (int k = 0; k < 24; k++) begin
            put(VEC[k].sk, VEC[k].iv, VEC[k].op, VEC[k].sa, VEC[k].sb, VEC[k].d,
                VEC[k].rv, VEC[k].rt, VEC[k].rd);
            see($sformatf("R6 vector %0d", k), VEC[k].ev, VEC[k].eop, VEC[k].ea, VEC[k].eb, VEC[k].ed);
            chk($sformatf("R10 vector %0d full", k), 32'(full), 0);
        end

        // directed: fill, refuse while full, drain in age order
        do_reset();
        put(0,1,1,0,0,7, 0,0,0);
        see("R1 R8 producer held", 0,0,0,0,0);
        put(0,1,2,7,7,2, 0,0,0);
        see("R1 R8 producer dispatched", 1,1,16'h00A0,16'h00A0,7);
        put(0,1,3,7,7,3, 0,0,0);
        see("R3 consumer waits", 0,0,0,0,0);
        put(0,1,4,7,7,4, 0,0,0);
        put(0,1,5,7,7,5, 0,0,0);
        chk("R10 not yet full", 32'(full), 0);
        put(0,1,6,0,0,6, 0,0,0);
        chk("R10 full", 32'(full), 1);
        see("R10 nothing ready", 0,0,0,0,0);
        put(0,0,0,0,0,0, 1,7,16'h7777);
        chk("R10 still full", 32'(full), 1);
        put(0,0,0,0,0,0, 0,0,0);
        see("R4 R7 first woken", 1,2,16'h7777,16'h7777,2);
        put(0,0,0,0,0,0, 0,0,0);
        see("R7 second", 1,3,16'h7777,16'h7777,3);
        put(0,0,0,0,0,0, 0,0,0);
        see("R7 third", 1,4,16'h7777,16'h7777,4);
        put(0,0,0,0,0,0, 0,0,0);
        see("R7 fourth", 1,5,16'h7777,16'h7777,5);
        put(1,1,7,6,6,0, 0,0,0);
        see("R10 refused issue left r6 ready", 1,7,16'h00A6,16'h00A6,0);
        put(0,0,0,0,0,0, 0,0,0);
        see("R10 refused issue never stored", 0,0,0,0,0);
        chk("R10 empty not full", 32'(full), 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule